// File: doc/BRIEF.md
# RS-485 Half-Duplex UART Transmitter with Driver-Enable Sequencing

This block serializes bytes onto a two-wire half-duplex RS-485 link and controls the transceiver's driver-enable line itself. A byte comes in over a valid/ready handshake and waits in a one-entry holding slot. In automatic direction mode the block first drives the bus idle-high for one full bit period. It then sends the character frame: a low start bit, the data bits least significant first, an optional parity bit, and one or two high stop bits. It keeps the driver enabled until the last configured stop bit has run its full period, and releases the bus on the very edge where that bit ends. The hold time therefore always matches the configured frame length, so the final stop bit is never cut short when the line goes to tri-state.

Parity mode, stop-bit count and the bit-period divisor are sampled at frame boundaries only. The divisor is the number of clock cycles per bit, so the clock frequency divided by the baud rate gives its value (for example about 1085 for 115200 baud on a 125 MHz clock). Bytes offered while a frame is in flight go out back to back, with no idle gap and no drop of the enable. In manual direction mode a host-driven enable input alone controls the driver, and frames start without the settling period.

Top module: `rs485_uart_tx`

## Requirements
- R1: A frame is a start bit at 0, then the 8 data bits least significant first, each bit lasting exactly `cfg_div` clock cycles; `cfg_div` values 0 and 1 act as 2.
- R2: `cfg_parity` encodes 2'b01 odd (data ones plus parity bit is odd), 2'b10 even (that count is even), and 2'b00 or 2'b11 none, in which case the parity slot is omitted entirely.
- R3: `cfg_two_stop` = 1 appends two full stop-bit periods at 1 after the data or parity bit; 0 appends one.
- R4: In automatic mode, `drv_en` and `busy` rise one cycle after a byte is accepted while idle, and `ser_out` stays 1 for one full bit period before the start bit.
- R5: In automatic mode, `drv_en` stays 1 through the last cycle of the final stop bit and falls on the next clock edge, so the enabled span is one bit period plus 10, 11 or 12 bit periods per frame depending on parity and stop settings.
- R6: A byte accepted while a frame is in flight starts its start bit on the cycle right after the previous frame's last stop bit, with `drv_en` held high across the join.
- R7: When `cfg_manual` is 1 while idle, `drv_en` follows `host_en` with one cycle of delay regardless of frame activity, and the start bit begins one cycle after acceptance with no settling period.
- R8: Changes to `cfg_parity`, `cfg_two_stop` or `cfg_div` during a frame do not alter that frame.
- R9: In automatic mode `busy` equals `drv_en` at all times; `busy` falls only on the edge that ends the last frame.
- R10: `in_ready` is 1 exactly when the one-entry holding slot is empty; `ser_out` is 1 whenever no frame bit is being sent.
- R11: After reset, `ser_out` = 1, `drv_en` = 0, `busy` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Byte to transmit |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Holding slot free; byte taken when valid and ready |
| cfg_parity | input | 2 | Parity mode: 00 none, 01 odd, 10 even, 11 none |
| cfg_two_stop | input | 1 | 1 = two stop bits, 0 = one |
| cfg_div | input | 16 | Clock cycles per bit (minimum effective 2) |
| cfg_manual | input | 1 | 1 = host controls driver enable |
| host_en | input | 1 | Driver enable request used in manual mode |
| ser_out | output | 1 | Serial data line, idle 1 |
| drv_en | output | 1 | Transceiver driver enable |
| busy | output | 1 | Settling period or frame in progress |

## Verification
Single frames are sent with data values whose count of ones is odd and even (0x01, 0x05, 0x55, 0x00, 0xFF). Under every parity code these separate a wrong parity polarity from an omitted or misplaced parity slot. Each frame is checked at the first and last cycle of every bit, and at the release edge. This tells a shortened or missing final stop bit apart from a late release, and a one-stop frame apart from a two-stop one. Random bursts of one to three bytes under random parity, stop and divisor settings (including the clamped divisors 0 and 1) show whether chained frames join without a gap. Some single-byte bursts have their configuration scrambled mid-frame, which catches settings that leak into a frame already in flight. A directed manual-mode sequence toggles `host_en` during and after a frame to separate host gating from automatic timing.

// File: rtl/rs485_tx_pkg.sv
package rs485_tx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ODD  = 2'b01,
        PAR_EVEN = 2'b10,
        PAR_OFF  = 2'b11
    } par_mode_e;

    typedef enum logic [1:0] {
        DIR_IDLE = 2'b00,
        DIR_PRE  = 2'b01,
        DIR_SEND = 2'b10
    } dir_state_e;

endpackage

// File: rtl/rs485_baud_gen.sv
module rs485_baud_gen #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam logic [DIV_W-1:0] MIN_PERIOD = DIV_W'(2);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } baud_st_t;

    baud_st_t st_d, st_q;
    logic [DIV_W-1:0] period;

    assign period = (div < MIN_PERIOD) ? MIN_PERIOD : div;
    assign tick   = run && (st_q.cnt == period - DIV_W'(1));

    always_comb begin
        st_d = st_q;
        if (!run || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rs485_frame_ser.sv
module rs485_frame_ser
    import rs485_tx_pkg::*;
#(
    parameter int unsigned DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [DATA_BITS-1:0] ld_data,
    input  logic [1:0]           ld_par,
    input  logic                 ld_two,
    input  logic                 tick,
    output logic                 line,
    output logic                 last_end
);
    localparam int unsigned FW = DATA_BITS + 4;
    localparam int unsigned CW = $clog2(FW + 1);
    localparam int unsigned PAR_POS = DATA_BITS + 1;

    typedef struct packed {
        logic [FW-1:0] sh;
        logic [CW-1:0] left;
    } ser_st_t;

    ser_st_t   st_d, st_q;
    par_mode_e pm;
    logic      par_on;
    logic      par_bit;

    assign pm      = par_mode_e'(ld_par);
    assign par_on  = (pm == PAR_ODD) || (pm == PAR_EVEN);
    assign par_bit = (pm == PAR_ODD) ? ~(^ld_data) : (^ld_data);

    assign line     = (st_q.left != '0) ? st_q.sh[0] : 1'b1;
    assign last_end = tick && (st_q.left == CW'(1));

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.sh                = '1;
            st_d.sh[0]             = 1'b0;
            st_d.sh[DATA_BITS:1]   = ld_data;
            if (par_on) begin
                st_d.sh[PAR_POS]   = par_bit;
            end
            st_d.left = CW'(DATA_BITS + 2) + CW'(par_on) + CW'(ld_two);
        end else if (tick && (st_q.left != '0)) begin
            st_d.sh   = {1'b1, st_q.sh[FW-1:1]};
            st_d.left = st_q.left - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sh   <= '1;
            st_q.left <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rs485_dir_ctl.sv
module rs485_dir_ctl
    import rs485_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_vld,
    input  logic manual,
    input  logic host_en,
    input  logic tick,
    input  logic last_end,
    output logic load,
    output logic run,
    output logic drv_en,
    output logic busy,
    output logic mode_man
);
    typedef struct packed {
        dir_state_e st;
        logic       man;
        logic       en;
        logic       bsy;
    } dir_st_t;

    dir_st_t st_d, st_q;

    assign run      = (st_q.st != DIR_IDLE);
    assign drv_en   = st_q.en;
    assign busy     = st_q.bsy;
    assign mode_man = st_q.man;

    always_comb begin
        st_d = st_q;
        load = 1'b0;
        unique case (st_q.st)
            DIR_IDLE: begin
                st_d.man = manual;
                if (hold_vld) begin
                    if (manual) begin
                        st_d.st = DIR_SEND;
                        load    = 1'b1;
                    end else begin
                        st_d.st = DIR_PRE;
                    end
                end
            end
            DIR_PRE: begin
                if (tick) begin
                    st_d.st = DIR_SEND;
                    load    = 1'b1;
                end
            end
            DIR_SEND: begin
                if (last_end) begin
                    if (hold_vld) begin
                        load = 1'b1;
                    end else begin
                        st_d.st = DIR_IDLE;
                    end
                end
            end
            default: st_d.st = DIR_IDLE;
        endcase
        st_d.bsy = (st_d.st != DIR_IDLE);
        st_d.en  = st_d.man ? host_en : st_d.bsy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.st  <= DIR_IDLE;
            st_q.man <= 1'b0;
            st_q.en  <= 1'b0;
            st_q.bsy <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rs485_uart_tx.sv
module rs485_uart_tx
    import rs485_tx_pkg::*;
#(
    parameter int unsigned DATA_BITS = 8,
    parameter int unsigned DIV_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DATA_BITS-1:0] in_data,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [1:0]           cfg_parity,
    input  logic                 cfg_two_stop,
    input  logic [DIV_W-1:0]     cfg_div,
    input  logic                 cfg_manual,
    input  logic                 host_en,
    output logic                 ser_out,
    output logic                 drv_en,
    output logic                 busy
);
    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic                 vld;
        logic [DIV_W-1:0]     div;
    } hold_st_t;

    hold_st_t st_d, st_q;
    logic     tick;
    logic     load;
    logic     run;
    logic     last_end;
    logic     mode_man;

    assign in_ready = ~st_q.vld;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.vld = 1'b0;
        end
        if (in_valid && in_ready) begin
            st_d.data = in_data;
            st_d.vld  = 1'b1;
        end
        if (!busy || load) begin
            st_d.div = cfg_div;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.data <= '0;
            st_q.vld  <= 1'b0;
            st_q.div  <= DIV_W'(2);
        end else begin
            st_q <= st_d;
        end
    end

    rs485_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (st_q.div),
        .tick  (tick)
    );

    rs485_frame_ser #(.DATA_BITS(DATA_BITS)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .ld_data  (st_q.data),
        .ld_par   (cfg_parity),
        .ld_two   (cfg_two_stop),
        .tick     (tick),
        .line     (ser_out),
        .last_end (last_end)
    );

    rs485_dir_ctl u_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_vld (st_q.vld),
        .manual   (cfg_manual),
        .host_en  (host_en),
        .tick     (tick),
        .last_end (last_end),
        .load     (load),
        .run      (run),
        .drv_en   (drv_en),
        .busy     (busy),
        .mode_man (mode_man)
    );
endmodule

// File: rtl/rs485_uart_tx_chk.sv
module rs485_uart_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic host_en,
    input logic ser_out,
    input logic drv_en,
    input logic busy,
    input logic mode_man
);
    a_r1_low_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_out |-> busy);

    a_r4_idle_at_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !mode_man) |-> ser_out);

    a_r4_settle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !mode_man) |=> ser_out);

    a_r5_stop_before_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(ser_out) && ser_out));

    a_r7_host_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_man && $past(mode_man)) |-> (drv_en == $past(host_en)));

    a_r9_busy_matches_en: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_man |-> (drv_en == busy));

    a_r10_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);
endmodule

bind rs485_uart_tx rs485_uart_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .host_en  (host_en),
    .ser_out  (ser_out),
    .drv_en   (drv_en),
    .busy     (busy),
    .mode_man (mode_man)
);

// File: tb/tb_rs485_uart_tx.sv
`timescale 1ns/1ps
module tb_rs485_uart_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  cfg_parity = 2'b00;
    logic        cfg_two_stop = 1'b0;
    logic [15:0] cfg_div = 16'd4;
    logic        cfg_manual = 1'b0;
    logic        host_en = 1'b0;
    logic        ser_out;
    logic        drv_en;
    logic        busy;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [7:0] bytes [3];

    always #4 clk = ~clk;

    rs485_uart_tx dut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop),
        .cfg_div(cfg_div), .cfg_manual(cfg_manual), .host_en(host_en),
        .ser_out(ser_out), .drv_en(drv_en), .busy(busy)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    function automatic int eff_period(input int div);
        return (div < 2) ? 2 : div;
    endfunction

    // Expected frame from the requirements: bit 0 sent first.
    function automatic void exp_frame(input logic [7:0] d, input logic [1:0] par,
                                      input logic two, output logic [11:0] bits,
                                      output int len, output int par_pos);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += int'(d[i]);
        bits = '1;
        bits[0] = 1'b0;
        for (int i = 0; i < 8; i++) bits[i+1] = d[i];
        len = 10;
        par_pos = -1;
        if (par == 2'b01 || par == 2'b10) begin
            par_pos = 9;
            bits[9] = (par == 2'b01) ? ((ones % 2) == 0) : ((ones % 2) == 1);
            len = 11;
        end
        if (two) len++;
    endfunction

    task automatic feed(input int nb);
        for (int i = 0; i < nb; i++) begin
            bit got = 1'b0;
            in_data  = bytes[i];
            in_valid = 1'b1;
            while (!got) begin
                got = in_ready;
                @(posedge clk);
                #2;
            end
            in_valid = 1'b0;
        end
    endtask

    task automatic run_burst(input int nb, input logic [1:0] par, input logic two,
                             input int div, input bit scramble);
        int p = eff_period(div);
        int w = 0;
        cfg_parity   = par;
        cfg_two_stop = two;
        cfg_div      = 16'(div);
        cfg_manual   = 1'b0;
        fork
            feed(nb);
        join_none
        if (scramble) begin
            fork
                begin
                    repeat (4 * p) @(posedge clk);
                    #2;
                    cfg_parity   = par ^ 2'b11;
                    cfg_two_stop = ~two;
                    cfg_div      = 16'(div + 3);
                end
            join_none
        end
        do begin
            step(1);
            w++;
        end while (!drv_en && w < 8);
        chk("R4 enable rises", drv_en, 1'b1);
        chk("R9 busy with enable", busy, 1'b1);
        chk("R4 line high at enable", ser_out, 1'b1);
        step(p - 1);
        chk("R4 line high end of settle", ser_out, 1'b1);
        chk("R4 enable during settle", drv_en, 1'b1);
        for (int i = 0; i < nb; i++) begin
            logic [11:0] bits;
            int len;
            int pp;
            exp_frame(bytes[i], par, two, bits, len, pp);
            for (int k = 0; k < len; k++) begin
                string lbl;
                if (k == 0) lbl = (i > 0) ? "R6 start no gap" : "R1 start bit";
                else if (k <= 8) lbl = "R1 data bit";
                else if (k == pp) lbl = "R2 parity bit";
                else lbl = "R3 stop bit";
                if (scramble) lbl = {"R8 ", lbl};
                step(1);
                chk(lbl, ser_out, bits[k]);
                step(p - 1);
                chk(lbl, ser_out, bits[k]);
                chk("R5 enable held in frame", drv_en, 1'b1);
            end
        end
        step(1);
        chk("R5 release after last stop", drv_en, 1'b0);
        chk("R9 busy falls with release", busy, 1'b0);
        chk("R10 idle line high", ser_out, 1'b1);
        chk("R10 slot empty", in_ready, 1'b1);
    endtask

    task automatic manual_test();
        int w = 0;
        cfg_manual = 1'b1;
        host_en    = 1'b0;
        cfg_parity = 2'b10;
        cfg_two_stop = 1'b0;
        cfg_div    = 16'd3;
        step(1);
        in_data  = 8'h3C;
        in_valid = 1'b1;
        step(1);
        in_valid = 1'b0;
        chk("R10 slot full after accept", in_ready, 1'b0);
        step(1);
        chk("R7 start bit without settle", ser_out, 1'b0);
        chk("R7 busy in manual frame", busy, 1'b1);
        chk("R7 enable follows host low", drv_en, 1'b0);
        host_en = 1'b1;
        step(1);
        chk("R7 enable follows host high", drv_en, 1'b1);
        host_en = 1'b0;
        step(1);
        chk("R7 enable drops mid frame", drv_en, 1'b0);
        chk("R7 frame continues", busy, 1'b1);
        while (busy && w < 100) begin
            step(1);
            w++;
        end
        chk("R7 frame ends", busy, 1'b0);
        chk("R10 line high after manual frame", ser_out, 1'b1);
        host_en = 1'b1;
        step(1);
        chk("R7 enable while idle", drv_en, 1'b1);
        cfg_manual = 1'b0;
        step(1);
        chk("R9 auto idle ignores host", drv_en, 1'b0);
        host_en = 1'b0;
        step(1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        step(1);
        chk("R11 reset line", ser_out, 1'b1);
        chk("R11 reset enable", drv_en, 1'b0);
        chk("R11 reset busy", busy, 1'b0);
        chk("R11 reset ready", in_ready, 1'b1);

        bytes[0] = 8'h01; run_burst(1, 2'b01, 1'b0, 4, 1'b0);
        bytes[0] = 8'h05; run_burst(1, 2'b01, 1'b1, 4, 1'b0);
        bytes[0] = 8'h55; run_burst(1, 2'b10, 1'b0, 3, 1'b0);
        bytes[0] = 8'h00; run_burst(1, 2'b10, 1'b1, 2, 1'b0);
        bytes[0] = 8'hFF; run_burst(1, 2'b00, 1'b1, 5, 1'b0);
        bytes[0] = 8'h55; run_burst(1, 2'b11, 1'b0, 0, 1'b0);
        bytes[0] = 8'h3A; run_burst(1, 2'b01, 1'b0, 1085, 1'b0);
        bytes[0] = 8'hA5; bytes[1] = 8'h5A; bytes[2] = 8'h81;
        run_burst(3, 2'b01, 1'b1, 1, 1'b0);
        bytes[0] = 8'h96; run_burst(1, 2'b00, 1'b0, 6, 1'b1);

        manual_test();

        for (int it = 0; it < 60; it++) begin
            int nb = 1 + int'($urandom % 3);
            logic [1:0] par = 2'($urandom % 4);
            logic two = 1'($urandom % 2);
            int div = int'($urandom % 10);
            bit scr = (nb == 1) && (($urandom % 2) == 1);
            for (int i = 0; i < 3; i++) bytes[i] = 8'($urandom);
            run_burst(nb, par, two, div, scr);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule